// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C-bus target that lets a host reach sixteen byte-wide registers. The registers themselves live outside the block. The block watches the oversampled SCL and SDA lines and recognises START and STOP. It accepts an address byte, then takes a register-select byte, and after that either writes incoming data bytes into the selected register or streams that register's contents back to the host.

Two strap inputs fix the 7-bit bus address. Each strap carries a 2-bit code for how its pin is tied, and the codes are captured once, on the first clock after reset. The block pulls SDA low only through an output enable, so the line behaves as open drain. Every data byte of a write goes to the same register; the register index never advances.

The controller is one finite-state machine with these states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the address acknowledge.
- `ST_SEL`: shifts in the register-select byte.
- `ST_SEL_ACK`: drives the select acknowledge.
- `ST_WDATA`: shifts in a write byte.
- `ST_WDATA_ACK`: drives the data acknowledge.
- `ST_RDATA`: shifts a read byte out.
- `ST_RDATA_ACK`: samples the host's acknowledge.
- `ST_HOLD`: stays silent until START or STOP.

The transitions, all taken on a synchronised SCL falling edge unless stated otherwise:
- STOP from any state goes to `ST_IDLE`.
- START from any state goes to `ST_ADDR`, once the straps have been captured.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address and to `ST_HOLD` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_SEL` for a write and to `ST_RDATA` for a read.
- `ST_SEL` goes to `ST_SEL_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK` and back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` returns to `ST_RDATA` on a host ACK and goes to `ST_HOLD` on a NACK.

Top module: `i2c_regbank_target`

## Requirements
- R1: While reset is asserted, `sda_oe` and `reg_we` are both 0.
- R2: The 7-bit bus address is 0x48 + 4·B + S, where B is the `strap_base_i` code and S is the `strap_step_i` code. Codes are 00 = tied high, 01 = tied low, 10 = tied to SCL, 11 = tied to SDA. As an address byte with the direction bit cleared, this is 0x90 + 8·B + 2·S. The address byte sends the address in bits [7:1], MSB first, and bit 0 is the direction: 0 for write, 1 for read. A matching address byte is acknowledged.
- R3: An address byte that does not match gets no acknowledge. Until the next START or STOP, later bytes get no acknowledge and cause no register write.
- R4: The strap codes are captured on the first clock after reset is released. Later changes on the strap inputs do not change the address the block answers to.
- R5: In the register-select byte, bits [6:3] choose the register. Bits 7, 2, 1 and 0 have no effect on which register is written or read.
- R6: The block acknowledges, by pulling SDA low for the ninth clock, every byte it accepts: a matching address byte, the register-select byte and every write data byte.
- R7: Each write data byte gives exactly one single-cycle `reg_we` pulse, with `reg_sel` set to the selected index and `reg_wdata` set to the byte. Every data byte of one write goes to the same register.
- R8: After a repeated START and a matching address with the read flag, the block sends the selected register's value MSB first, one bit per SCL clock.
- R9: After a read byte, a host ACK (SDA low on the ninth clock) makes the block send the same register again. A host NACK makes it release SDA and stay silent until START or STOP.
- R10: STOP abandons a partly received byte without writing it and returns to idle. START at any point restarts address reception.
- R11: SDA is open drain: a 1 bit is sent by releasing the line. `sda_oe` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| strap_base_i | input | 2 | Tie code of the strap that picks the address base |
| strap_step_i | input | 2 | Tie code of the strap that picks the address offset |
| reg_we | output | 1 | One-cycle write strobe to the register bank |
| reg_sel | output | 4 | Selected register index |
| reg_wdata | output | 8 | Byte to be written |
| reg_rdata | input | 8 | Contents of the register at `reg_sel` |

## Verification
The address decode is tried with both extreme strap codes and with randomly drawn ones, and each address is paired with an address that differs from it in one random bit. This tells an exact match apart from a partial decode. Write bursts of random length and random data go to random registers, with random values in the ignored select bits. Reading the bytes back separates "same register every byte" from "auto-increment", and "bits [6:3] only" from a wider select field. Reads finish with an ACKed byte followed by a NACKed one. STOP and repeated START are issued in the middle of a byte, to show that a partial byte is dropped rather than committed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_IDX_W  = 4;
    localparam int DEV_ADDR_W = 7;
    localparam int STRAP_W    = 2;
    localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SEL,
        ST_SEL_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_HOLD
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_d;
    logic              sda_d;

    // Both lines pass through identical stages so their relative timing is kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & ~sda_s & sda_d;
    assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;

endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr
    import i2c_tgt_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] ADDR_ROOT = 7'h48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_base_i,
    input  logic [STRAP_W-1:0]    strap_step_i,
    output logic [DEV_ADDR_W-1:0] own_addr,
    output logic                  strap_done
);

    localparam int BASE_SHIFT = STRAP_W;

    logic [STRAP_W-1:0] base_q;
    logic [STRAP_W-1:0] step_q;

    // Capture once on the first clock after reset, then freeze.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            step_q     <= '0;
            strap_done <= 1'b0;
        end else if (!strap_done) begin
            base_q     <= strap_base_i;
            step_q     <= strap_step_i;
            strap_done <= 1'b1;
        end
    end

    always_comb begin
        own_addr = ADDR_ROOT
                 + (DEV_ADDR_W'(base_q) << BASE_SHIFT)
                 + DEV_ADDR_W'(step_q);
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int                    SYNC_STAGES = 2,
    parameter logic [DEV_ADDR_W-1:0] ADDR_ROOT   = 7'h48,
    parameter int                    SEL_LSB     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    input  logic [STRAP_W-1:0]   strap_base_i,
    input  logic [STRAP_W-1:0]   strap_step_i,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_sel,
    output logic [BYTE_W-1:0]    reg_wdata,
    input  logic [BYTE_W-1:0]    reg_rdata
);

    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);

    logic                  sda_s;
    logic                  scl_rise;
    logic                  scl_fall;
    logic                  start_det;
    logic                  stop_det;
    logic [DEV_ADDR_W-1:0] own_addr;
    logic                  strap_done;

    tgt_state_e            state_q;
    tgt_state_e            state_d;
    logic [BIT_CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0]     shift_q;
    logic                  rw_q;
    logic [REG_IDX_W-1:0]  sel_q;
    logic                  host_ack_q;
    logic                  byte_full;
    logic                  addr_hit;
    logic                  rx_phase;
    logic                  entering;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_strap_addr #(
        .ADDR_ROOT(ADDR_ROOT)
    ) u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_base_i(strap_base_i),
        .strap_step_i(strap_step_i),
        .own_addr    (own_addr),
        .strap_done  (strap_done)
    );

    assign byte_full = (bit_cnt_q == FULL_CNT);
    assign addr_hit  = (shift_q[BYTE_W-1:1] == own_addr);
    assign rx_phase  = (state_q == ST_ADDR) || (state_q == ST_SEL) || (state_q == ST_WDATA);
    assign entering  = (state_d != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: bus conditions first, then per-state progress on SCL falls
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det && strap_done) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: state_d = state_q;
                ST_ADDR: begin
                    if (scl_fall && byte_full) begin
                        state_d = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        state_d = rw_q ? ST_RDATA : ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (scl_fall && byte_full) state_d = ST_SEL_ACK;
                end
                ST_SEL_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && byte_full) state_d = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_RDATA: begin
                    if (scl_fall && byte_full) state_d = ST_RDATA_ACK;
                end
                ST_RDATA_ACK: begin
                    if (scl_fall) begin
                        state_d = host_ack_q ? ST_RDATA : ST_HOLD;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Byte datapath: bit counter, shifter, direction, register index, host ack
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shift_q    <= '0;
            rw_q       <= 1'b0;
            sel_q      <= '0;
            host_ack_q <= 1'b0;
        end else begin
            if (entering || start_det) begin
                bit_cnt_q <= '0;
            end else if (scl_rise && !byte_full && (rx_phase || state_q == ST_RDATA)) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (rx_phase && scl_rise && !byte_full) begin
                shift_q <= {shift_q[BYTE_W-2:0], sda_s};
            end else if (state_d == ST_RDATA && state_q != ST_RDATA) begin
                shift_q <= reg_rdata;
            end else if (state_q == ST_RDATA && scl_fall && !byte_full) begin
                shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
            end

            if (state_q == ST_ADDR && state_d == ST_ADDR_ACK) begin
                rw_q <= shift_q[0];
            end
            if (state_q == ST_SEL && state_d == ST_SEL_ACK) begin
                sel_q <= shift_q[SEL_LSB +: REG_IDX_W];
            end
            if (state_q == ST_RDATA_ACK && scl_rise) begin
                host_ack_q <= ~sda_s;
            end
        end
    end

    // Outputs
    always_comb begin
        reg_we = (state_q == ST_WDATA) && (state_d == ST_WDATA_ACK);
        unique case (state_q)
            ST_ADDR_ACK, ST_SEL_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~shift_q[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign reg_sel   = sel_q;
    assign reg_wdata = shift_q;

endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk
    import i2c_tgt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic                  reg_we,
    input logic                  stop_det,
    input tgt_state_e            state_q,
    input logic [DEV_ADDR_W-1:0] own_addr,
    input logic                  strap_done
);

    assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_done) |-> $stable(own_addr));

    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == ST_IDLE));

    assert_write_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> sda_oe);

    assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    assert_oe_rise_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    assert_hold_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (!sda_oe && !reg_we));

endmodule

bind i2c_regbank_target i2c_regbank_target_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .stop_det  (stop_det),
    .state_q   (state_q),
    .own_addr  (own_addr),
    .strap_done(strap_done)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap_base = 2'd0;
    logic [1:0] strap_step = 2'd0;
    logic       sda_oe;
    logic       sda_line;
    logic       reg_we;
    logic [3:0] reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] regs [16];
    logic [7:0] exp_regs [16];
    int         we_count = 0;
    int         n_checks = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regbank_target u_i2c_regbank_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .strap_base_i(strap_base),
        .strap_step_i(strap_step),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata)
    );

    // Register bank model behind the port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
        end else if (reg_we) begin
            regs[reg_sel] <= reg_wdata;
            we_count      <= we_count + 1;
        end
    end
    assign reg_rdata = regs[reg_sel];

    function automatic logic [6:0] exp_addr(input logic [1:0] b, input logic [1:0] s);
        return 7'h48 + {3'd0, b, 2'd0} + {5'd0, s};
    endfunction

    function automatic logic [7:0] sel_byte(input logic [3:0] idx, input logic [7:0] junk);
        return {junk[7], idx, 2'b00, junk[0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int k);
        for (int i = 7; i > 7 - k; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        acked = !sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] b, input logic [1:0] s);
        rst_n = 1'b0;
        strap_base = b;
        strap_step = s;
        tick(4);
        check(sda_oe == 1'b0 && reg_we == 1'b0, "R1", "outputs in reset",
              {sda_oe, reg_we}, 0);
        rst_n = 1'b1;
        tick(4);
        for (int i = 0; i < 16; i++) exp_regs[i] = 8'h00;
    endtask

    task automatic compare_bank(input string req);
        for (int i = 0; i < 16; i++) begin
            check(regs[i] == exp_regs[i], req, "register content", regs[i], exp_regs[i]);
        end
    endtask

    task automatic read_back(input logic [6:0] me, input logic [3:0] idx, input string req);
        logic       ack;
        logic [7:0] b;
        bus_start();
        send_byte({me, 1'b0}, ack);
        send_byte(sel_byte(idx, 8'($urandom)), ack);
        bus_start();
        send_byte({me, 1'b1}, ack);
        check(ack, "R8", "read address ack", ack, 1);
        recv_byte(1'b1, b);
        check(b == exp_regs[idx], req, "first read byte", b, exp_regs[idx]);
        recv_byte(1'b0, b);
        check(b == exp_regs[idx], "R9", "byte after host ack", b, exp_regs[idx]);
        tick(2);
        check(sda_oe == 1'b0, "R9", "released after nack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        logic [1:0] b_code;
        logic [1:0] s_code;
        logic [6:0] me;
        logic [6:0] other;
        logic [3:0] idx;
        logic [7:0] d;
        logic [7:0] rb;
        logic       ack;
        int         nb;
        int         wc0;

        void'($urandom(32'd1729));
        tick(3);

        for (int r = 0; r < 6; r++) begin
            b_code = (r == 0) ? 2'd0 : (r == 1) ? 2'd3 : 2'($urandom_range(3));
            s_code = (r == 0) ? 2'd0 : (r == 1) ? 2'd3 : 2'($urandom_range(3));
            do_reset(b_code, s_code);
            me = exp_addr(b_code, s_code);

            // R4: strap change after capture must not move the address
            strap_base = b_code + 2'd1;
            tick(2);
            bus_start();
            send_byte({exp_addr(strap_base, s_code), 1'b0}, ack);
            check(!ack, "R4", "late strap address ignored", ack, 0);
            bus_stop();

            // R2/R5/R6/R7: write burst to one register
            idx = 4'($urandom_range(15));
            nb  = 1 + $urandom_range(2);
            bus_start();
            send_byte({me, 1'b0}, ack);
            check(ack, "R2", "address ack", ack, 1);
            send_byte(sel_byte(idx, 8'($urandom)), ack);
            check(ack, "R6", "select ack", ack, 1);
            wc0 = we_count;
            for (int k = 0; k < nb; k++) begin
                d = 8'($urandom);
                send_byte(d, ack);
                check(ack, "R6", "data ack", ack, 1);
                exp_regs[idx] = d;
            end
            bus_stop();
            tick(2);
            check(we_count - wc0 == nb, "R7", "write strobes", we_count - wc0, nb);
            compare_bank("R7");

            // R5/R8/R9: read back with different ignored bits
            read_back(me, idx, "R5");

            // R3: mismatched address
            other = me ^ (7'd1 << $urandom_range(6));
            wc0 = we_count;
            bus_start();
            send_byte({other, 1'b0}, ack);
            check(!ack, "R3", "mismatch address nack", ack, 0);
            send_byte(8'($urandom), ack);
            check(!ack, "R3", "byte after mismatch", ack, 0);
            send_byte(8'($urandom), ack);
            bus_stop();
            tick(2);
            check(we_count == wc0, "R3", "no write after mismatch", we_count, wc0);

            // R10: STOP inside a data byte
            bus_start();
            send_byte({me, 1'b0}, ack);
            send_byte(sel_byte(idx, 8'h00), ack);
            wc0 = we_count;
            send_bits(8'($urandom), 4);
            bus_stop();
            tick(2);
            check(we_count == wc0, "R10", "partial byte dropped", we_count, wc0);
            check(regs[idx] == exp_regs[idx], "R10", "register kept", regs[idx], exp_regs[idx]);

            // R10: repeated START inside a data byte
            bus_start();
            send_byte({me, 1'b0}, ack);
            send_byte(sel_byte(idx, 8'h81), ack);
            send_bits(8'($urandom), 3);
            bus_start();
            send_byte({me, 1'b1}, ack);
            check(ack, "R10", "restart address ack", ack, 1);
            recv_byte(1'b0, rb);
            check(rb == exp_regs[idx], "R10", "read after restart", rb, exp_regs[idx]);
            bus_stop();
        end

        // R11: alternating bit pattern through the open-drain output
        do_reset(2'd2, 2'd1);
        me = exp_addr(2'd2, 2'd1);
        bus_start();
        send_byte({me, 1'b0}, ack);
        send_byte(sel_byte(4'd9, 8'hFF), ack);
        send_byte(8'hA5, ack);
        check(ack, "R6", "directed data ack", ack, 1);
        exp_regs[9] = 8'hA5;
        bus_stop();
        bus_start();
        send_byte({me, 1'b0}, ack);
        send_byte(sel_byte(4'd9, 8'h00), ack);
        bus_start();
        send_byte({me, 1'b1}, ack);
        recv_byte(1'b0, rb);
        check(rb == 8'hA5, "R11", "open-drain pattern", rb, 8'hA5);
        bus_stop();
        tick(4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule